// File: doc/BRIEF.md
# Selectable Noise Rejection Filter with Edge Detection

This block cleans up one external interrupt pin before it reaches the interrupt controller. The pin can carry a remote-control receiver signal or a timer event, so it may be noisy. The raw pin first passes through a two-flop synchronizer. It is then sampled on the ticks of a filter clock, which software derives from the instruction cycle by dividing it by 1, 32 or 128. A new level is passed to the filtered output only when two consecutive filter samples agree and differ from the level the output holds now.

The filtered level drives an edge detector. This detector raises a one-cycle interrupt request on a rising edge, a falling edge or either edge, as a 2-bit detect field selects. Detection can also be switched off. Each clock cycle of `clk` counts as one instruction cycle. When the filter select changes, the divider phase and the sample history are restarted, so the switch alone cannot create an edge.

Top module: `noise_reject_irq`

## Requirements
- R1: While `rst_n` is low and right after it is released, `flt_level` and `irq_pulse` are 0.
- R2: `flt_sel` picks the filter tick spacing: 2'b00 gives 1 cycle, 2'b01 gives DIV_MID cycles (32), and both 2'b10 and 2'b11 give DIV_SLOW cycles (128). Consecutive ticks under an unchanged select are exactly that many cycles apart.
- R3: With a spacing of 1, a pin level held for 2 or more cycles is passed and a 1-cycle pulse is rejected. A level change on the pin appears on `flt_level` 3 clock edges after the edge that first captures it.
- R4: With a spacing of 32, a pin level held for 64 or more cycles is passed. A level held for 32 or fewer cycles, high-going or low-going, never reaches `flt_level`.
- R5: With a spacing of 128, a pin level held for 256 or more cycles is passed, and one held for 128 or fewer cycles never reaches `flt_level`.
- R6: `flt_level` changes only at the clock edge of a filter tick, and only when the current sample equals the previous sample.
- R7: `det_mode` selects detection: 2'b00 off, 2'b01 rising edges of `flt_level`, 2'b10 falling edges, 2'b11 both edges. A passed pulse therefore gives 0, 1, 1 or 2 requests.
- R8: `irq_pulse` lasts exactly one cycle and rises at the same edge at which `flt_level` takes its new value.
- R9: A change of `flt_sel` restarts the divider and loads the sample history with the current output. The select change itself leaves `flt_level` unchanged and raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | 1 | Unsynchronized external pin |
| flt_sel | input | 2 | Filter time base select |
| det_mode | input | 2 | Detection type select |
| flt_level | output | 1 | Filtered pin level |
| irq_pulse | output | 1 | One-cycle interrupt request |

## Verification
The assertions check on every cycle that the tick spacing matches the select, that the output moves only on ticks, and that a request is a single cycle tied to an output change in an enabled direction. They also check that both-edge mode never misses a change and that a select switch never moves the output. The minimum and maximum accepted pulse widths for each time base can only be shown by the bench's sweeps of pulse lengths, as can the exact three-edge latency and the per-mode request counts. The same holds for low-going glitch rejection and for quiet select switching under a steady pin.

// File: rtl/noise_reject_irq.sv
module noise_reject_irq #(
  parameter int DIV_MID     = 32,
  parameter int DIV_SLOW    = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_raw,
  input  logic [1:0] flt_sel,
  input  logic [1:0] det_mode,
  output logic       flt_level,
  output logic       irq_pulse
);

  localparam int CW = $clog2(DIV_SLOW);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   pin_s;
  logic [1:0]             sel_q;
  logic [CW-1:0]          cnt;
  logic [CW:0]            lim;
  logic                   smp;
  logic                   sel_chg;
  logic                   tick;
  logic                   upd;

  assign pin_s = sync_q[SYNC_STAGES-1];

  always_comb begin
    case (flt_sel)
      2'b00:   lim = (CW+1)'(1);
      2'b01:   lim = (CW+1)'(DIV_MID);
      default: lim = (CW+1)'(DIV_SLOW);
    endcase
  end

  assign sel_chg = (flt_sel != sel_q);
  assign tick    = !sel_chg && ({1'b0, cnt} == lim - (CW+1)'(1));
  assign upd     = tick && (pin_s == smp) && (pin_s != flt_level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= '0;
      sel_q     <= 2'b00;
      cnt       <= '0;
      smp       <= 1'b0;
      flt_level <= 1'b0;
      irq_pulse <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_raw};
      sel_q  <= flt_sel;
      if (sel_chg || tick) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
      if (sel_chg)   smp <= flt_level;
      else if (tick) smp <= pin_s;
      if (upd) flt_level <= pin_s;
      irq_pulse <= upd && (pin_s ? det_mode[0] : det_mode[1]);
    end
  end

endmodule

// File: rtl/noise_reject_irq_chk.sv
module noise_reject_irq_chk #(
  parameter int DIV_MID  = 32,
  parameter int DIV_SLOW = 128
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] flt_sel,
  input logic [1:0] det_mode,
  input logic       flt_level,
  input logic       irq_pulse,
  input logic       tick
);

  logic [1:0]  sel_prev;
  logic [15:0] gap;
  logic        gap_ok;
  logic [15:0] lim_exp;

  assign lim_exp = (flt_sel == 2'b00) ? 16'd1 :
                   (flt_sel == 2'b01) ? 16'(DIV_MID) : 16'(DIV_SLOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_prev <= 2'b00;
      gap      <= '0;
      gap_ok   <= 1'b0;
    end else begin
      sel_prev <= flt_sel;
      if (flt_sel != sel_prev) begin
        gap    <= '0;
        gap_ok <= 1'b0;
      end else if (tick) begin
        gap    <= '0;
        gap_ok <= 1'b1;
      end else begin
        gap <= gap + 16'd1;
      end
    end
  end

  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick && gap_ok |-> gap == lim_exp - 16'd1);

  p_change_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flt_level != $past(flt_level) |-> $past(tick));

  p_irq_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> (flt_level ? $past(det_mode[0]) : $past(det_mode[1])));

  p_both_edges_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_level != $past(flt_level)) && ($past(det_mode) == 2'b11) |-> irq_pulse);

  p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

  p_irq_on_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> flt_level != $past(flt_level));

  p_sel_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flt_sel != sel_prev |=> $stable(flt_level));

endmodule

bind noise_reject_irq noise_reject_irq_chk #(.DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flt_sel(flt_sel), .det_mode(det_mode),
  .flt_level(flt_level), .irq_pulse(irq_pulse), .tick(tick)
);

// File: tb/noise_reject_irq_bench.sv
module noise_reject_irq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_raw = 1'b0;
  logic [1:0] flt_sel = 2'b00;
  logic [1:0] det_mode = 2'b00;
  logic       flt_level;
  logic       irq_pulse;

  int checks = 0;
  int failures = 0;
  bit mon_en = 0;
  int irq_seen = 0;
  bit hi_seen = 0;
  bit lo_seen = 0;
  bit done = 0;

  always #4 clk = ~clk;

  noise_reject_irq u_noise_reject_irq (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .flt_sel(flt_sel),
    .det_mode(det_mode), .flt_level(flt_level), .irq_pulse(irq_pulse)
  );

  always @(negedge clk) begin
    if (mon_en) begin
      if (irq_pulse) irq_seen++;
      if (flt_level) hi_seen = 1;
      else           lo_seen = 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic mon_start();
    irq_seen = 0; hi_seen = 0; lo_seen = 0; mon_en = 1;
  endtask

  function automatic int base_of(input logic [1:0] s);
    return (s == 2'b00) ? 1 : (s == 2'b01) ? 32 : 128;
  endfunction

  initial begin
    cyc(3);
    chk(flt_level == 0, "R1 level in reset", flt_level, 0);
    chk(irq_pulse == 0, "R1 irq in reset", irq_pulse, 0);
    rst_n = 1'b1;
    cyc(2);
    chk(flt_level == 0 && irq_pulse == 0, "R1 after release", {flt_level, irq_pulse}, 0);

    // R3 exact latency and R8 pulse width, rising then falling
    det_mode = 2'b01;
    cyc(2);
    pin_raw = 1'b1;
    cyc(3);
    chk(flt_level == 0, "R3 not yet risen", flt_level, 0);
    cyc(1);
    chk(flt_level == 1, "R3 rise latency", flt_level, 1);
    chk(irq_pulse == 1, "R8 irq with rise", irq_pulse, 1);
    cyc(1);
    chk(irq_pulse == 0, "R8 irq one cycle", irq_pulse, 0);
    det_mode = 2'b10;
    cyc(2);
    pin_raw = 1'b0;
    cyc(3);
    chk(flt_level == 1, "R3 not yet fallen", flt_level, 1);
    cyc(1);
    chk(flt_level == 0, "R3 fall latency", flt_level, 0);
    chk(irq_pulse == 1, "R7 falling irq", irq_pulse, 1);
    cyc(1);
    chk(irq_pulse == 0, "R8 irq one cycle fall", irq_pulse, 0);

    // sweep of time bases, detect modes and pulse lengths
    for (int s = 0; s < 4; s++) begin
      for (int d = 0; d < 4; d++) begin
        flt_sel = 2'(s);
        det_mode = 2'(d);
        cyc(4);
        for (int k = 0; k < 5; k++) begin
          int n = base_of(2'(s));
          int len = (k == 0) ? 1 : (k == 1) ? ((n / 2 > 0) ? n / 2 : 1) :
                    (k == 2) ? n : (k == 3) ? 2 * n : 2 * n + 5;
          bit acc = (len >= 2 * n);
          int exp_irq = acc ? (d[0] + d[1]) : 0;
          string tg = (s == 0) ? "R3 R7" : (s == 1) ? "R4 R7" : (s == 2) ? "R5 R7" : "R2 R7";
          mon_start();
          pin_raw = 1'b1;
          cyc(len);
          pin_raw = 1'b0;
          cyc(3 * n + 8);
          mon_en = 0;
          chk(hi_seen == acc, $sformatf("%s pass sel=%0d det=%0d len=%0d", tg, s, d, len), hi_seen, acc);
          chk(irq_seen == exp_irq, $sformatf("%s irq count sel=%0d det=%0d len=%0d", tg, s, d, len), irq_seen, exp_irq);
          chk(flt_level == 0, $sformatf("%s settled low sel=%0d len=%0d", tg, s, len), flt_level, 0);
        end
      end
    end

    // R4 low-going glitch rejected while the output is high
    flt_sel = 2'b01;
    det_mode = 2'b11;
    pin_raw = 1'b1;
    cyc(3 * 32 + 8);
    chk(flt_level == 1, "R4 settled high", flt_level, 1);
    mon_start();
    pin_raw = 1'b0;
    cyc(20);
    pin_raw = 1'b1;
    cyc(3 * 32 + 8);
    mon_en = 0;
    chk(lo_seen == 0, "R4 low glitch rejected", lo_seen, 0);
    chk(irq_seen == 0, "R4 no irq on low glitch", irq_seen, 0);

    // R9 select switching under a steady pin
    flt_sel = 2'b00;
    cyc(10);
    mon_start();
    flt_sel = 2'b01; cyc(6);
    flt_sel = 2'b10; cyc(6);
    flt_sel = 2'b11; cyc(6);
    flt_sel = 2'b00; cyc(6);
    mon_en = 0;
    chk(lo_seen == 0, "R9 level held across select changes", lo_seen, 0);
    chk(irq_seen == 0, "R9 no irq from select changes", irq_seen, 0);
    pin_raw = 1'b0;
    cyc(8);
    chk(flt_level == 0, "R6 follows pin after switches", flt_level, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule